// File: doc/BRIEF.md
# Framed Link Transmitter

This block sits on the front-end side of a serial optical link. It takes events from a local source as a stream of 16-bit words and turns them into the word stream that drives an 8b/10b encoder and serializer. Each source word holds a 12-bit payload and a 4-bit label. The source uses a valid/ready handshake and marks the final word of each event with a last flag. On every clock cycle the block produces one 16-bit word and one K flag per byte. The encoder, the serializer and the optical transmitter are not part of this block.

Only two control words are used. The idle word fills every cycle in which no event is on the wire. The carrier-extend word marks the packet boundaries: one goes directly before the first data word and one directly after the last data word. There is no header code and no length field, so the receiver finds the packet edges only from a carrier-extend word sitting next to data.

Once a packet has started, the source must supply a word on every cycle until the last one. If a word is missing, the packet is cut short: the block sends the trailing carrier extend at once and raises an error flag for that one cycle. A configurable number of idle words separates consecutive packets.

Top module: `link_frame_tx`

## Requirements
- R1: A byte whose K flag is set always holds 0xBC (K28.5) or 0xF7 (K23.7). No other control character, including the error code, is ever sent.
- R2: In every cycle with no packet on the wire, the output is the idle word. The idle word has 0xBC in bits 15:8 and 0xC5 (D5.6) in bits 7:0, with tx_kflag = 2'b10. tx_kflag[1] covers bits 15:8.
- R3: A packet opens with the carrier-extend word 0xF7F7 with tx_kflag = 2'b11. The very next cycle carries the first data word.
- R4: In the cycle right after the last data word of a packet, the output is the trailing carrier extend 0xF7F7 with tx_kflag = 2'b11.
- R5: Each event produces exactly one packet. A single-word event produces exactly carrier extend, data, carrier extend.
- R6: A data word is sent with tx_kflag = 2'b00. Its label is in bits 15:12 and its payload in bits 11:0. Data words go out in the order they were accepted, one cycle after acceptance.
- R7: src_ready is high only in the leading carrier-extend cycle and in data cycles whose outgoing word is not the last. A word is accepted at a clock edge where src_valid and src_ready are both high.
- R8: If src_valid is low while src_ready is high inside a packet, the next cycle is a trailing carrier extend. underrun_err is high for exactly that cycle, and the missing word is never sent.
- R9: At least MIN_GAP idle words separate a trailing carrier extend from the next leading carrier extend.
- R10: While reset is held, the output is the idle word, src_ready is low and underrun_err is low. A packet that was partly sent when reset arrived gets no trailing carrier extend.
- R11: src_ready is low in idle cycles. An idle cycle with src_valid high, once the gap has been met, is followed by the leading carrier extend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 1 | Source word present |
| src_ready | output | 1 | Block takes the word at this edge |
| src_payload | input | PAYLOAD_W (12) | Event data bits |
| src_label | input | LABEL_W (4) | Label identifying the word |
| src_last | input | 1 | Word is the last of its event |
| tx_word | output | 16 | Word to the 8b/10b encoder |
| tx_kflag | output | 2 | Per-byte control flag; bit 1 covers bits 15:8 |
| underrun_err | output | 1 | Packet aborted because the source ran dry |

## Verification
A wrong state in the sequencer shows up on tx_word in the same cycle. A missing or extra carrier extend, or an idle inside a packet, appears on the wire at once, and src_ready shifts at the same edge. A stale or wrongly captured hold register gives a wrong data word one cycle after the handshake. A wrong gap counter shows as a packet starting one cycle early, which a bench that tracks idle runs between packets catches at that packet's leading carrier extend. Since every output depends only on registers, a cycle model compared on every clock localizes each fault to the first cycle it appears.

// File: rtl/lft_pkg.sv
package lft_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LEAD  = 2'd1,
      ST_DATA  = 2'd2,
      ST_TRAIL = 2'd3
   } lft_state_e;

   localparam logic [7:0] K28_5 = 8'hBC;
   localparam logic [7:0] D5_6  = 8'hC5;
   localparam logic [7:0] K23_7 = 8'hF7;

endpackage

// File: rtl/lft_ctrl.sv
module lft_ctrl
   import lft_pkg::*;
#(
   parameter int MIN_GAP = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       src_valid,
   input  logic       last_q,
   output lft_state_e state_q,
   output logic       src_ready,
   output logic       load,
   output logic       err_q
);

   localparam int GW = $clog2(MIN_GAP + 1);

   initial begin
      if (MIN_GAP < 1) $error("lft_ctrl: MIN_GAP must be at least 1");
   end

   lft_state_e    state_d;
   logic [GW-1:0] gap_q;
   logic          gap_ok;
   logic          err_d;

   assign gap_ok    = (int'(gap_q) + 1) >= MIN_GAP;
   assign src_ready = (state_q == ST_LEAD) || ((state_q == ST_DATA) && !last_q);
   assign load      = src_ready && src_valid;

   always_comb begin
      state_d = state_q;
      err_d   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (src_valid && gap_ok) state_d = ST_LEAD;
         end
         ST_LEAD: begin
            if (src_valid) begin
               state_d = ST_DATA;
            end else begin
               state_d = ST_TRAIL;
               err_d   = 1'b1;
            end
         end
         ST_DATA: begin
            if (last_q) begin
               state_d = ST_TRAIL;
            end else if (!src_valid) begin
               state_d = ST_TRAIL;
               err_d   = 1'b1;
            end
         end
         ST_TRAIL: state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         gap_q   <= GW'(MIN_GAP);
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         err_q   <= err_d;
         if (state_q == ST_TRAIL) begin
            gap_q <= '0;
         end else if ((state_q == ST_IDLE) && (int'(gap_q) < MIN_GAP)) begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end

   p_ready_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      src_ready |-> (state_q == ST_LEAD || state_q == ST_DATA));

   p_lead_then_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LEAD && src_valid) |=> (state_q == ST_DATA));

   p_last_then_trail_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DATA && last_q) |=> (state_q == ST_TRAIL && !err_q));

   p_trail_then_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TRAIL) |=> (state_q == ST_IDLE));

   p_err_only_on_trail_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (state_q == ST_TRAIL));

   p_idle_no_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !src_ready);

endmodule

// File: rtl/lft_hold.sv
module lft_hold #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word_in,
   input  logic              last_in,
   output logic [WORD_W-1:0] word_q,
   output logic              last_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         last_q <= 1'b0;
      end else if (load) begin
         word_q <= word_in;
         last_q <= last_in;
      end
   end

endmodule

// File: rtl/lft_encode.sv
module lft_encode
   import lft_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter bit CTRL_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lft_state_e        state_q,
   input  logic [WORD_W-1:0] word_q,
   output logic [WORD_W-1:0] tx_word,
   output logic [1:0]        tx_kflag
);

   logic [WORD_W-1:0] idle_word;
   logic [1:0]        idle_k;

   generate
      if (CTRL_HIGH) begin : g_k_high
         assign idle_word = {K28_5, D5_6};
         assign idle_k    = 2'b10;
      end else begin : g_k_low
         assign idle_word = {D5_6, K28_5};
         assign idle_k    = 2'b01;
      end
   endgenerate

   always_comb begin
      unique case (state_q)
         ST_IDLE: begin
            tx_word  = idle_word;
            tx_kflag = idle_k;
         end
         ST_DATA: begin
            tx_word  = word_q;
            tx_kflag = 2'b00;
         end
         default: begin
            tx_word  = {K23_7, K23_7};
            tx_kflag = 2'b11;
         end
      endcase
   end

   p_kcode_legal_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_kflag[1] |-> (tx_word[15:8] == K28_5 || tx_word[15:8] == K23_7));

   p_kcode_legal_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_kflag[0] |-> (tx_word[7:0] == K28_5 || tx_word[7:0] == K23_7));

   p_data_no_k_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DATA) |-> (tx_kflag == 2'b00));

endmodule

// File: rtl/link_frame_tx.sv
module link_frame_tx
   import lft_pkg::*;
#(
   parameter int PAYLOAD_W = 12,
   parameter int LABEL_W   = 4,
   parameter int MIN_GAP   = 1,
   parameter bit CTRL_HIGH = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 src_valid,
   output logic                 src_ready,
   input  logic [PAYLOAD_W-1:0] src_payload,
   input  logic [LABEL_W-1:0]   src_label,
   input  logic                 src_last,
   output logic [15:0]          tx_word,
   output logic [1:0]           tx_kflag,
   output logic                 underrun_err
);

   localparam int WORD_W = PAYLOAD_W + LABEL_W;

   initial begin
      if (WORD_W != 16) $error("link_frame_tx: payload plus label must fill 16 bits");
   end

   lft_state_e        state_q;
   logic              load;
   logic              last_q;
   logic [WORD_W-1:0] word_q;

   lft_ctrl #(.MIN_GAP(MIN_GAP)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_valid (src_valid),
      .last_q    (last_q),
      .state_q   (state_q),
      .src_ready (src_ready),
      .load      (load),
      .err_q     (underrun_err)
   );

   lft_hold #(.WORD_W(WORD_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .word_in ({src_label, src_payload}),
      .last_in (src_last),
      .word_q  (word_q),
      .last_q  (last_q)
   );

   lft_encode #(.WORD_W(WORD_W), .CTRL_HIGH(CTRL_HIGH)) u_enc (
      .clk      (clk),
      .rst_n    (rst_n),
      .state_q  (state_q),
      .word_q   (word_q),
      .tx_word  (tx_word),
      .tx_kflag (tx_kflag)
   );

   p_accept_shows_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (src_valid && src_ready) |=> (tx_kflag == 2'b00 && tx_word == $past({src_label, src_payload})));

   p_underrun_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
      underrun_err |-> (tx_kflag == 2'b11 && tx_word == 16'hF7F7));

endmodule

// File: tb/link_frame_tx_tb.sv
module link_frame_tx_tb;

   localparam int GAP = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        src_valid = 1'b0;
   logic        src_ready;
   logic [11:0] src_payload = '0;
   logic [3:0]  src_label = '0;
   logic        src_last = 1'b0;
   logic [15:0] tx_word;
   logic [1:0]  tx_kflag;
   logic        underrun_err;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   link_frame_tx #(.MIN_GAP(GAP)) u_dut (
      .clk (clk), .rst_n (rst_n), .src_valid (src_valid), .src_ready (src_ready),
      .src_payload (src_payload), .src_label (src_label), .src_last (src_last),
      .tx_word (tx_word), .tx_kflag (tx_kflag), .underrun_err (underrun_err)
   );

   // behavioural model: phase 0 idle, 1 opening CE, 2 data, 3 closing CE
   int          m_phase = 0;
   int          m_idles = GAP;
   logic [15:0] m_word  = '0;
   bit          m_last  = 0;
   bit          m_err   = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_idles = GAP; m_err = 0; m_last = 0;
      end else begin
         m_err = 0;
         if (m_phase == 0) begin
            m_idles++;
            if (src_valid && m_idles >= GAP) m_phase = 1;
         end else if (m_phase == 1 || (m_phase == 2 && !m_last)) begin
            if (src_valid) begin
               m_word = {src_label, src_payload}; m_last = src_last; m_phase = 2;
            end else begin
               m_phase = 3; m_err = 1;
            end
         end else if (m_phase == 2) begin
            m_phase = 3;
         end else begin
            m_phase = 0; m_idles = 0;
         end
      end
   end

   int  leads_seen = 0;
   int  leads_exp  = 0;
   int  idle_run   = 0;
   bit  had_trail  = 0;
   bit  prev_ce    = 0;
   bit  prev_data  = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic compare();
      logic [15:0] ew;
      logic [1:0]  ek;
      string       tag;
      bit          er;
      case (m_phase)
         0: begin ew = 16'hBCC5; ek = 2'b10; tag = "R2"; end
         1: begin ew = 16'hF7F7; ek = 2'b11; tag = "R3"; end
         2: begin ew = m_word;   ek = 2'b00; tag = "R6"; end
         default: begin ew = 16'hF7F7; ek = 2'b11; tag = "R4"; end
      endcase
      er = (m_phase == 1) || (m_phase == 2 && !m_last);
      chk(tx_word == ew, tag, tx_word, ew);
      chk(tx_kflag == ek, tag, tx_kflag, ek);
      chk(src_ready == er, (m_phase == 0) ? "R11" : "R7", src_ready, er);
      chk(underrun_err == m_err, "R8", underrun_err, m_err);
      // R1: any K byte is one of the two allowed control characters
      chk((!tx_kflag[1] || tx_word[15:8] == 8'hBC || tx_word[15:8] == 8'hF7) &&
          (!tx_kflag[0] || tx_word[7:0] == 8'hBC || tx_word[7:0] == 8'hF7),
          "R1", tx_word, 16'hF7F7);
      // packet boundary bookkeeping from the wire only
      if (tx_kflag == 2'b11) begin
         if (!prev_data && !prev_ce) begin
            leads_seen++;
            if (had_trail) chk(idle_run >= GAP, "R9", idle_run, GAP);
         end else begin
            had_trail = 1;
         end
         prev_ce = 1; prev_data = 0;
      end else if (tx_kflag == 2'b00) begin
         prev_data = 1; prev_ce = 0;
      end else begin
         if (prev_ce || prev_data) idle_run = 0;
         idle_run++;
         prev_ce = 0; prev_data = 0;
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic send_packet(input int n, input int base, input int drop_at);
      bit acc;
      leads_exp += (drop_at > 0 && drop_at < n) ? 2 : 1;
      for (int i = 0; i < n; i++) begin
         if (i == drop_at) begin
            src_valid = 1'b0;
            tick();
         end
         src_valid   = 1'b1;
         src_payload = 12'(base + i);
         src_label   = 4'(i + 3);
         src_last    = (i == n - 1);
         do begin
            acc = src_ready;
            tick();
         end while (!acc);
      end
      src_valid = 1'b0;
      src_last  = 1'b0;
   endtask

   initial begin
      #100000;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      // R10: idle output during reset, even with a source word waiting
      src_valid = 1'b1;
      chk(tx_word == 16'hBCC5 && tx_kflag == 2'b10, "R10", tx_word, 16'hBCC5);
      chk(!src_ready && !underrun_err, "R10", {src_ready, underrun_err}, 0);
      tick();
      src_valid = 1'b0;
      rst_n = 1'b1;
      tick(); tick();

      send_packet(4, 12'h100, -1);          // R3 R4 R6 plain packet
      tick(); tick();
      send_packet(1, 12'h2AA, -1);          // R5 single word
      send_packet(3, 12'h300, -1);          // R9 back to back
      send_packet(5, 12'h400, -1);
      tick();
      send_packet(6, 12'h500, 3);           // R8 underrun mid packet
      tick(); tick(); tick();
      send_packet(2, 12'hFFF, 1);           // R8 underrun after first word
      tick(); tick();

      // R10: reset during a packet discards it with no closing CE
      leads_exp++;
      src_valid = 1'b1; src_payload = 12'h777; src_label = 4'h9; src_last = 1'b0;
      tick(); tick(); tick(); tick();
      rst_n = 1'b0;
      #1;
      chk(tx_word == 16'hBCC5 && tx_kflag == 2'b10, "R10", tx_word, 16'hBCC5);
      chk(!src_ready, "R10", src_ready, 0);
      tick();
      src_valid = 1'b0;
      rst_n = 1'b1;
      tick();
      chk(tx_word == 16'hBCC5, "R10", tx_word, 16'hBCC5);
      had_trail = 0; prev_ce = 0; prev_data = 0;
      tick();

      send_packet(2, 12'h0AB, -1);
      tick(); tick(); tick();

      chk(leads_seen == leads_exp, "R5", leads_seen, leads_exp);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule